// File: doc/BRIEF.md
# Low-Power Mode Wake Sequencer

This block controls the clocks and oscillators of a small microcontroller as it goes into and comes out of two low-power states. In Sleep the core and peripheral clocks are gated off while the internal RC oscillator and the flash stay powered. Power-down goes further and also disables the RC oscillator and the flash. Entry runs in a fixed order: the PLL is disconnected first, then the PLL is switched off and both clock dividers are forced to zero, then the clock gate closes, and last the oscillators are stopped. A wake-capable interrupt or a reset ends either state.

The time before the CPU resumes depends on the oscillator that was in use when the request was accepted. The block records that source at entry. A wake from Power-down on the RC oscillator first waits out the RC start-up. A separate flash timer then counts RC cycles, so the CPU can run from SRAM before the flash is ready. The PLL and the dividers are not restored on wake. They keep their reset values until software sets them again through single-cycle request pins.

All pins are plain levels or single-cycle strobes, so there is no back-pressure. The oscillator clocks reach the block as single-cycle tick enables in the reference clock domain `clk`.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset: clock gate enabled, main, RC and RTC oscillators enabled, flash enabled, flash_ready high, PLL powered off and disconnected, both divider-zero flags high, cpu_resume low.
- R2: An accepted entry request (enter_req high in run) clears pll_connect at that edge. The next edge clears pll_pwr_en and sets both divider-zero flags. The edge after that drops clk_gate_en. The following edge reaches the low-power state.
- R3: In the low-power state main_osc_en is low and rtc_osc_en stays high. With enter_pd=0 (Sleep), rc_osc_en, flash_en and flash_ready stay high. With enter_pd=1 (Power-down), all three are low.
- R4: Wake from Sleep with src_main=0 (RC source) pulses cpu_resume on the 4th rc_tick counted after the edge that samples wake_irq.
- R5: With src_main=1 (main oscillator source), cpu_resume pulses on the 4096th main_tick counted after the wake edge, in either mode.
- R6: Wake from Power-down with the RC source first waits 240 ref_tick cycles, or until rc_ready is sampled high if that comes first. It then counts 4 rc_tick cycles before pulsing cpu_resume.
- R7: After a Power-down wake, flash_ready rises 400 rc_tick cycles after the RC start-up completes, whether cpu_resume came earlier or later.
- R8: The oscillator source and the mode are latched when entry is accepted. Changing src_main later does not alter the wake delay.
- R9: A wake_irq sampled during any of the three entry steps returns the block to run at that edge, with the clock gate open and no wake delay.
- R10: cpu_resume is a one-cycle pulse, issued on every return to run other than reset, in the same cycle that clk_gate_en reopens.
- R11: pll_on_req sets pll_pwr_en, pll_conn_req sets pll_connect only while the PLL is powered, and cdiv_load and udiv_load clear the divider-zero flags. These requests act only in run, and a wake restores none of these outputs.
- R12: wake_irq in run has no effect. enter_req is ignored while flash_ready is low.
- R13: Reset during any step returns to the run defaults and clears the pending wake counters, so the next wake takes its full nominal delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to enter a low-power state |
| enter_pd | input | 1 | 1 selects Power-down, 0 selects Sleep |
| src_main | input | 1 | 1 when the main oscillator is the clock source, 0 for RC |
| wake_irq | input | 1 | Wake-capable interrupt |
| rc_tick | input | 1 | One RC oscillator cycle |
| main_tick | input | 1 | One main oscillator cycle |
| ref_tick | input | 1 | Timebase tick for the RC start-up timeout |
| rc_ready | input | 1 | RC oscillator reports stable output |
| pll_on_req | input | 1 | Software request to power the PLL |
| pll_conn_req | input | 1 | Software request to connect the PLL |
| cdiv_load | input | 1 | Software loads the CPU clock divider |
| udiv_load | input | 1 | Software loads the USB clock divider |
| rtc_osc_en | output | 1 | 32 kHz RTC oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| main_osc_en | output | 1 | Main oscillator path enable |
| pll_pwr_en | output | 1 | PLL power enable |
| pll_connect | output | 1 | PLL output selected as clock |
| flash_en | output | 1 | Flash power enable |
| clk_gate_en | output | 1 | Core and peripheral clock gate enable |
| cclk_div_zero | output | 1 | CPU clock divider forced to zero |
| usb_div_zero | output | 1 | USB clock divider forced to zero |
| cpu_resume | output | 1 | One-cycle pulse when execution resumes |
| flash_ready | output | 1 | Flash access allowed |

## Verification
The assertions assume that every input is synchronous to `clk` and that the tick pins are single-cycle enables. They also assume that rc_ready is never high while the RC oscillator is disabled and before it has stabilised. The stimulus drives every input on the falling edge and holds the three tick inputs high, so the wake delays are exact cycle counts. rc_ready is raised only once, partway through a Power-down wake. Software requests are issued only in run, apart from one connect request that is deliberately made while the PLL is off.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  // Controller steps, in the order taken on entry
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_DISC   = 3'd1,
    PS_PLLOFF = 3'd2,
    PS_GATE   = 3'd3,
    PS_LOW    = 3'd4,
    PS_WAKE   = 3'd5
  } pwr_state_e;

endpackage

// File: rtl/pwr_tick_cnt.sv
module pwr_tick_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic hit
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  // hit marks the tick that completes LIMIT counted ticks
  assign hit = tick && !clear && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_rc_startup.sv
module pwr_rc_startup #(
  parameter int unsigned START_REFS = 240,
  parameter bit          USE_RDY    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_off,
  input  logic ref_tick,
  input  logic rc_ready,
  output logic rc_up
);
  logic rc_up_q;
  logic cnt_hit;
  logic rdy_hit;

  generate
    if (USE_RDY) begin : g_rdy
      assign rdy_hit = rc_ready && !rc_off;
    end else begin : g_timeout_only
      assign rdy_hit = 1'b0;
    end
  endgenerate

  pwr_tick_cnt #(.LIMIT(START_REFS)) u_start_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (rc_up_q || rc_off),
    .tick  (ref_tick),
    .hit   (cnt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                rc_up_q <= 1'b1;
    else if (rc_off)                           rc_up_q <= 1'b0;
    else if (!rc_up_q && (cnt_hit || rdy_hit)) rc_up_q <= 1'b1;
  end

  assign rc_up = rc_up_q;
endmodule

// File: rtl/pwr_flash_timer.sv
module pwr_flash_timer #(
  parameter int unsigned FLASH_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flash_off,
  input  logic rc_up,
  input  logic rc_tick,
  output logic flash_ready
);
  logic ready_q;
  logic cnt_hit;

  pwr_tick_cnt #(.LIMIT(FLASH_CYC)) u_flash_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ready_q || flash_off),
    .tick  (rc_up && rc_tick),
    .hit   (cnt_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ready_q <= 1'b1;
    else if (flash_off) ready_q <= 1'b0;
    else if (cnt_hit)   ready_q <= 1'b1;
  end

  assign flash_ready = ready_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       enter_pd,
  input  logic       src_main,
  input  logic       wake_irq,
  input  logic       flash_ready,
  input  logic       wake_done,
  output pwr_state_e state_q,
  output logic       pd_q,
  output logic       src_q,
  output logic       accept,
  output logic       enter_low,
  output logic       resume_q
);
  pwr_state_e state_d;

  assign accept    = (state_q == PS_RUN) && enter_req && flash_ready;
  assign enter_low = (state_q == PS_GATE) && !wake_irq;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:    if (accept)   state_d = PS_DISC;
      PS_DISC:   state_d = wake_irq ? PS_RUN : PS_PLLOFF;
      PS_PLLOFF: state_d = wake_irq ? PS_RUN : PS_GATE;
      PS_GATE:   state_d = wake_irq ? PS_RUN : PS_LOW;
      PS_LOW:    if (wake_irq)  state_d = PS_WAKE;
      PS_WAKE:   if (wake_done) state_d = PS_RUN;
      default:   state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_RUN;
      pd_q     <= 1'b0;
      src_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= (state_q != PS_RUN) && (state_d == PS_RUN);
      if (accept) begin
        pd_q  <= enter_pd;
        src_q <= src_main;
      end
    end
  end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pwr_wake_pkg::*;
#(
  parameter int unsigned RC_WAKE_CYC   = 4,
  parameter int unsigned MAIN_WAKE_CYC = 4096,
  parameter int unsigned RC_START_REFS = 240,
  parameter int unsigned FLASH_CYC     = 400,
  parameter bit          USE_RC_READY  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic enter_pd,
  input  logic src_main,
  input  logic wake_irq,
  input  logic rc_tick,
  input  logic main_tick,
  input  logic ref_tick,
  input  logic rc_ready,
  input  logic pll_on_req,
  input  logic pll_conn_req,
  input  logic cdiv_load,
  input  logic udiv_load,
  output logic rtc_osc_en,
  output logic rc_osc_en,
  output logic main_osc_en,
  output logic pll_pwr_en,
  output logic pll_connect,
  output logic flash_en,
  output logic clk_gate_en,
  output logic cclk_div_zero,
  output logic usb_div_zero,
  output logic cpu_resume,
  output logic flash_ready
);
  pwr_state_e state_q;
  logic pd_q, src_q, accept, enter_low, resume_q;
  logic rc_up, deep_off, in_run, in_wake;
  logic rc_hit, main_hit;
  logic pll_pwr_q, pll_conn_q, cdiv_zero_q, udiv_zero_q;

  pwr_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_req   (enter_req),
    .enter_pd    (enter_pd),
    .src_main    (src_main),
    .wake_irq    (wake_irq),
    .flash_ready (flash_ready),
    .wake_done   (rc_hit || main_hit),
    .state_q     (state_q),
    .pd_q        (pd_q),
    .src_q       (src_q),
    .accept      (accept),
    .enter_low   (enter_low),
    .resume_q    (resume_q)
  );

  assign in_run   = (state_q == PS_RUN);
  assign in_wake  = (state_q == PS_WAKE);
  // Power-down removes RC and flash from the edge that enters the low state
  assign deep_off = pd_q && (enter_low || state_q == PS_LOW);

  pwr_rc_startup #(
    .START_REFS (RC_START_REFS),
    .USE_RDY    (USE_RC_READY)
  ) u_rc_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .rc_off   (deep_off),
    .ref_tick (ref_tick),
    .rc_ready (rc_ready),
    .rc_up    (rc_up)
  );

  pwr_flash_timer #(.FLASH_CYC(FLASH_CYC)) u_flash (
    .clk         (clk),
    .rst_n       (rst_n),
    .flash_off   (deep_off),
    .rc_up       (rc_up),
    .rc_tick     (rc_tick),
    .flash_ready (flash_ready)
  );

  // Resume delay counters, one per latched source
  pwr_tick_cnt #(.LIMIT(RC_WAKE_CYC)) u_rc_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!in_wake),
    .tick  (!src_q && rc_up && rc_tick),
    .hit   (rc_hit)
  );

  pwr_tick_cnt #(.LIMIT(MAIN_WAKE_CYC)) u_main_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!in_wake),
    .tick  (src_q && main_tick),
    .hit   (main_hit)
  );

  // PLL and divider state: forced during entry, set again only by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_pwr_q   <= 1'b0;
      pll_conn_q  <= 1'b0;
      cdiv_zero_q <= 1'b1;
      udiv_zero_q <= 1'b1;
    end else begin
      if (accept)
        pll_conn_q <= 1'b0;
      else if (in_run && pll_conn_req && pll_pwr_q)
        pll_conn_q <= 1'b1;

      if (state_q == PS_DISC)
        pll_pwr_q <= 1'b0;
      else if (in_run && pll_on_req && !accept)
        pll_pwr_q <= 1'b1;

      if (state_q == PS_DISC)
        cdiv_zero_q <= 1'b1;
      else if (in_run && cdiv_load && !accept)
        cdiv_zero_q <= 1'b0;

      if (state_q == PS_DISC)
        udiv_zero_q <= 1'b1;
      else if (in_run && udiv_load && !accept)
        udiv_zero_q <= 1'b0;
    end
  end

  assign rtc_osc_en    = 1'b1;
  assign rc_osc_en     = !(pd_q && state_q == PS_LOW);
  assign flash_en      = !(pd_q && state_q == PS_LOW);
  assign main_osc_en   = (state_q != PS_LOW);
  assign clk_gate_en   = in_run || (state_q == PS_DISC) || (state_q == PS_PLLOFF);
  assign pll_pwr_en    = pll_pwr_q;
  assign pll_connect   = pll_conn_q;
  assign cclk_div_zero = cdiv_zero_q;
  assign usb_div_zero  = udiv_zero_q;
  assign cpu_resume    = resume_q;
endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk
  import pwr_wake_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pwr_state_e state,
  input logic       enter_req,
  input logic       cpu_resume,
  input logic       clk_gate_en,
  input logic       pll_pwr_en,
  input logic       pll_connect,
  input logic       cclk_div_zero,
  input logic       usb_div_zero,
  input logic       flash_en,
  input logic       flash_ready,
  input logic       main_osc_en
);
  // R10
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resume |=> !cpu_resume);

  // R10
  gate_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> cpu_resume);

  // R11
  conn_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_connect |-> pll_pwr_en);

  // R2
  gated_pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> (!pll_connect && !pll_pwr_en && cclk_div_zero && usb_div_zero));

  // R3
  flash_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_en |-> !flash_ready);

  // R3
  low_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_LOW) |-> (!main_osc_en && !clk_gate_en));

  // R12
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && enter_req && !flash_ready) |=> (state == PS_RUN));
endmodule

bind pwr_wake_seq pwr_wake_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state         (state_q),
  .enter_req     (enter_req),
  .cpu_resume    (cpu_resume),
  .clk_gate_en   (clk_gate_en),
  .pll_pwr_en    (pll_pwr_en),
  .pll_connect   (pll_connect),
  .cclk_div_zero (cclk_div_zero),
  .usb_div_zero  (usb_div_zero),
  .flash_en      (flash_en),
  .flash_ready   (flash_ready),
  .main_osc_en   (main_osc_en)
);

// File: tb/pwr_wake_seq_bench.sv
module pwr_wake_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_req = 0, enter_pd = 0, src_main = 0, wake_irq = 0;
  logic rc_tick = 1, main_tick = 1, ref_tick = 1, rc_ready = 0;
  logic pll_on_req = 0, pll_conn_req = 0, cdiv_load = 0, udiv_load = 0;
  logic rtc_osc_en, rc_osc_en, main_osc_en, pll_pwr_en, pll_connect;
  logic flash_en, clk_gate_en, cclk_div_zero, usb_div_zero, cpu_resume, flash_ready;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwr_wake_seq u_pwr_wake_seq (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_pd(enter_pd),
    .src_main(src_main), .wake_irq(wake_irq), .rc_tick(rc_tick),
    .main_tick(main_tick), .ref_tick(ref_tick), .rc_ready(rc_ready),
    .pll_on_req(pll_on_req), .pll_conn_req(pll_conn_req),
    .cdiv_load(cdiv_load), .udiv_load(udiv_load),
    .rtc_osc_en(rtc_osc_en), .rc_osc_en(rc_osc_en), .main_osc_en(main_osc_en),
    .pll_pwr_en(pll_pwr_en), .pll_connect(pll_connect), .flash_en(flash_en),
    .clk_gate_en(clk_gate_en), .cclk_div_zero(cclk_div_zero),
    .usb_div_zero(usb_div_zero), .cpu_resume(cpu_resume), .flash_ready(flash_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_run_defaults(input string req);
    chk({req, " clk_gate_en"}, clk_gate_en, 1);
    chk({req, " main_osc_en"}, main_osc_en, 1);
    chk({req, " rc_osc_en"}, rc_osc_en, 1);
    chk({req, " rtc_osc_en"}, rtc_osc_en, 1);
    chk({req, " flash_en"}, flash_en, 1);
    chk({req, " flash_ready"}, flash_ready, 1);
    chk({req, " pll_pwr_en"}, pll_pwr_en, 0);
    chk({req, " pll_connect"}, pll_connect, 0);
    chk({req, " cclk_div_zero"}, cclk_div_zero, 1);
    chk({req, " usb_div_zero"}, usb_div_zero, 1);
    chk({req, " cpu_resume"}, cpu_resume, 0);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  // Accepted entry, then three more edges into the low state
  task automatic go_low(input bit pd, input bit src);
    @(negedge clk);
    enter_req = 1; enter_pd = pd; src_main = src;
    @(posedge clk); @(negedge clk);
    enter_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // Wake and count edges after the wake edge until resume and flash ready
  task automatic wake_measure(input int rdy_at, output int rn, output int fn);
    int n = 0;
    rn = -1; fn = -1;
    @(negedge clk); wake_irq = 1;
    @(posedge clk); @(negedge clk);
    wake_irq = 0;
    if (flash_ready) fn = 0;
    while ((rn < 0 || fn < 0) && n < 6000) begin
      if (n == rdy_at) rc_ready = 1;
      @(posedge clk); n++;
      @(negedge clk);
      if (rn < 0 && cpu_resume) rn = n;
      if (fn < 0 && flash_ready) fn = n;
    end
    rc_ready = 0;
  endtask

  task automatic t_reset;
    chk_run_defaults("R1 reset");
  endtask

  task automatic t_ignore_run;
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    chk("R12 wake in run resume", cpu_resume, 0);
    chk("R12 wake in run gate", clk_gate_en, 1);
  endtask

  task automatic t_pll_sw;
    pulse(pll_conn_req);
    chk("R11 connect refused while PLL off", pll_connect, 0);
    pulse(pll_on_req);
    chk("R11 pll on", pll_pwr_en, 1);
    pulse(pll_conn_req);
    chk("R11 pll connect", pll_connect, 1);
    pulse(cdiv_load);
    chk("R11 cpu divider loaded", cclk_div_zero, 0);
    chk("R11 usb divider untouched", usb_div_zero, 1);
    pulse(udiv_load);
    chk("R11 usb divider loaded", usb_div_zero, 0);
  endtask

  task automatic t_entry_order;
    int rn, fn;
    @(negedge clk);
    enter_req = 1; enter_pd = 0; src_main = 0;
    @(posedge clk); @(negedge clk); enter_req = 0;
    chk("R2 step0 connect", pll_connect, 0);
    chk("R2 step0 pll power", pll_pwr_en, 1);
    chk("R2 step0 gate", clk_gate_en, 1);
    @(posedge clk); @(negedge clk);
    chk("R2 step1 pll power", pll_pwr_en, 0);
    chk("R2 step1 cdiv", cclk_div_zero, 1);
    chk("R2 step1 udiv", usb_div_zero, 1);
    chk("R2 step1 gate", clk_gate_en, 1);
    @(posedge clk); @(negedge clk);
    chk("R2 step2 gate", clk_gate_en, 0);
    chk("R2 step2 main osc", main_osc_en, 1);
    @(posedge clk); @(negedge clk);
    chk("R3 sleep main osc", main_osc_en, 0);
    chk("R3 sleep rc osc", rc_osc_en, 1);
    chk("R3 sleep flash_en", flash_en, 1);
    chk("R3 sleep flash_ready", flash_ready, 1);
    chk("R3 sleep rtc", rtc_osc_en, 1);
    wake_measure(-1, rn, fn);
    chk("R4 sleep rc resume delay", rn, 4);
    chk("R11 pll stays off after wake", pll_pwr_en, 0);
    chk("R11 dividers stay zero after wake", cclk_div_zero + usb_div_zero, 2);
    chk("R10 gate open after resume", clk_gate_en, 1);
  endtask

  task automatic t_sleep_main;
    int rn, fn;
    go_low(0, 1);
    wake_measure(-1, rn, fn);
    chk("R5 sleep main resume delay", rn, 4096);
  endtask

  task automatic t_pd_rc;
    int rn, fn;
    go_low(1, 0);
    chk("R3 pd rc osc", rc_osc_en, 0);
    chk("R3 pd flash_en", flash_en, 0);
    chk("R3 pd flash_ready", flash_ready, 0);
    chk("R3 pd rtc", rtc_osc_en, 1);
    wake_measure(-1, rn, fn);
    chk("R6 pd rc resume delay", rn, 244);
    chk("R7 pd flash ready delay", fn, 640);
  endtask

  task automatic t_pd_busy;
    int n = 0;
    go_low(1, 0);
    @(negedge clk); wake_irq = 1;
    @(posedge clk); @(negedge clk); wake_irq = 0;
    while (!cpu_resume && n < 1000) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk("R7 resume before flash ready", flash_ready, 0);
    enter_req = 1; enter_pd = 0;
    @(negedge clk); enter_req = 0;
    repeat (4) @(negedge clk);
    chk("R12 entry ignored while flash not ready", clk_gate_en, 1);
    while (!flash_ready && n < 2000) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk("R7 flash ready reached", flash_ready, 1);
  endtask

  task automatic t_pd_main;
    int rn, fn;
    go_low(1, 1);
    wake_measure(-1, rn, fn);
    chk("R5 pd main resume delay", rn, 4096);
    chk("R7 pd main flash delay", fn, 640);
  endtask

  task automatic t_rdy;
    int rn, fn;
    go_low(1, 0);
    wake_measure(9, rn, fn);
    chk("R6 rc_ready shortens startup", rn, 14);
    chk("R7 flash after ready startup", fn, 410);
  endtask

  task automatic t_latch;
    int rn, fn;
    go_low(0, 0);
    src_main = 1;
    wake_measure(-1, rn, fn);
    chk("R8 latched rc source", rn, 4);
    src_main = 0;
  endtask

  task automatic t_abort;
    @(negedge clk);
    enter_req = 1; enter_pd = 0; src_main = 1;
    @(posedge clk); @(negedge clk);
    enter_req = 0; wake_irq = 1;
    @(posedge clk); @(negedge clk);
    wake_irq = 0;
    chk("R9 abort at first step gate", clk_gate_en, 1);
    chk("R10 abort resume pulse", cpu_resume, 1);
    @(negedge clk);
    chk("R10 resume one cycle", cpu_resume, 0);
    @(negedge clk);
    enter_req = 1;
    @(posedge clk); @(negedge clk); enter_req = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R9 gate closed at third step", clk_gate_en, 0);
    wake_irq = 1;
    @(posedge clk); @(negedge clk);
    wake_irq = 0;
    chk("R9 abort at gate step reopens", clk_gate_en, 1);
    chk("R9 abort at gate step resume", cpu_resume, 1);
    chk("R9 main osc never stopped", main_osc_en, 1);
    src_main = 0;
  endtask

  task automatic t_reset_mid;
    int rn, fn;
    go_low(1, 1);
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    repeat (100) @(negedge clk);
    rst_n = 0;
    #1;
    chk_run_defaults("R13 reset mid wake");
    repeat (2) @(negedge clk);
    rst_n = 1;
    go_low(0, 0);
    wake_measure(-1, rn, fn);
    chk("R13 full delay after reset", rn, 4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignore_run();
    t_pll_sw();
    t_entry_order();
    t_sleep_main();
    t_pd_rc();
    t_pd_busy();
    t_pd_main();
    t_rdy();
    t_latch();
    t_abort();
    t_reset_mid();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule